// File: doc/BRIEF.md
# Early Depth Cull Filter

The block sits between the rasterizer and the fragment shader and throws away fragments that cannot affect the image, so the shader never spends cycles on them. Each incoming fragment carries a screen position, an unsigned depth and an opaque payload. Its depth is compared with the nearest depth held for its pixel in a small on-chip store, and with a programmable inclusive depth window. A fragment that lies behind the stored depth, or outside the window, is dropped and counted. Every other fragment is forwarded unchanged and in arrival order.

When the current draw uses a shader that may rewrite fragment depth, the early result cannot be trusted. A per-draw flag then turns the stage into a pass-through. Scissoring in x and y is already done upstream, so only depth is examined here. The test works per pixel; multisampling is not handled. A separate write port loads the per-pixel depths, and a clearable counter reports how many fragments were dropped.

Top module: `zcull_filter`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and cull_count is 0.
- R2: A fragment whose depth is strictly greater than the stored depth of its pixel is dropped. A fragment with equal or smaller depth is forwarded.
- R3: After reset, every store entry holds the maximum depth 0xFFFF, so any fragment inside the window passes at any pixel.
- R4: A store write with wr_en=1 sets the entry at index {wr_y, wr_x} to wr_z from the next cycle on. A fragment accepted in the same cycle as the write still sees the old entry.
- R5: A fragment with depth below cfg_zmin or above cfg_zmax is dropped. Depths equal to either bound pass.
- R6: While cfg_shader_writes_z is 1, every fragment is forwarded and none is counted, whatever its depth.
- R7: An accepted fragment that is not dropped appears on the output one cycle after acceptance, with x, y, depth and payload unchanged. Fragments leave in arrival order.
- R8: While out_valid=1 and out_ready=0, the output fields hold steady and in_ready is 0.
- R9: cull_count rises by exactly one for each dropped fragment. cull_clr=1 makes it 0 in the next cycle, and a clear wins over a drop in the same cycle.
- R10: The store index uses only the low 4 bits of x and y, so pixels 16 apart in either coordinate share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fragment offered |
| in_ready | output | 1 | Fragment can be taken |
| in_x | input | 8 | Fragment x |
| in_y | input | 8 | Fragment y |
| in_z | input | 16 | Fragment depth, larger is farther |
| in_payload | input | 32 | Opaque fragment data |
| cfg_shader_writes_z | input | 1 | 1 = shader may change depth, bypass culling |
| cfg_zmin | input | 16 | Lower bound of depth window, inclusive |
| cfg_zmax | input | 16 | Upper bound of depth window, inclusive |
| wr_en | input | 1 | Depth store write strobe |
| wr_x | input | 4 | Store column index |
| wr_y | input | 4 | Store row index |
| wr_z | input | 16 | Depth to store |
| out_valid | output | 1 | Forwarded fragment present |
| out_ready | input | 1 | Downstream takes fragment |
| out_x | output | 8 | Forwarded x |
| out_y | output | 8 | Forwarded y |
| out_z | output | 16 | Forwarded depth |
| out_payload | output | 32 | Forwarded payload |
| cull_clr | input | 1 | Synchronous clear of the drop counter |
| cull_count | output | 32 | Number of dropped fragments |

## Verification
The depth test is driven with depths above, equal to and below a loaded entry, which separates a strict compare from an inclusive one. Window tests place fragments one step outside each bound and exactly on each bound. The same fragments are then sent again with the bypass flag raised, which shows that the flag overrides both the depth test and the window test. Writes that coincide with a fragment, and coordinates that differ only above bit 3, show the read timing of the store and how it is indexed. A stalled output shows that a held fragment survives while the next one waits, and that order is kept.

// File: rtl/zcull_pkg.sv
package zcull_pkg;
    parameter int unsigned Z_W     = 16;
    parameter int unsigned COORD_W = 8;
    parameter int unsigned PAY_W   = 32;
    parameter int unsigned IDX_W   = 4;
    parameter int unsigned CNT_W   = 32;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [Z_W-1:0]     z;
        logic [PAY_W-1:0]   pay;
    } frag_t;
endpackage

// File: rtl/zc_depth_store.sv
module zc_depth_store #(
    parameter int unsigned Z_W   = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_x,
    input  logic [IDX_W-1:0] rd_y,
    output logic [Z_W-1:0]   rd_z,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_x,
    input  logic [IDX_W-1:0] wr_y,
    input  logic [Z_W-1:0]   wr_z
);
    localparam int unsigned DEPTH = 1 << (2 * IDX_W);

    typedef struct packed {
        logic [DEPTH-1:0][Z_W-1:0] mem;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.mem[{wr_y, wr_x}] = wr_z;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.mem <= '1;
        else        s_q     <= s_d;
    end

    // Read returns the registered entry: a write lands one cycle later.
    assign rd_z = s_q.mem[{rd_y, rd_x}];

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> s_q.mem[$past({wr_y, wr_x})] == $past(wr_z));
endmodule

// File: rtl/zc_compare.sv
module zc_compare #(
    parameter int unsigned Z_W = 16
) (
    input  logic [Z_W-1:0] frag_z,
    input  logic [Z_W-1:0] store_z,
    input  logic [Z_W-1:0] zmin,
    input  logic [Z_W-1:0] zmax,
    input  logic           bypass,
    output logic           cull
);
    logic behind, outside;

    always_comb begin
        behind  = frag_z > store_z;
        outside = (frag_z < zmin) || (frag_z > zmax);
        cull    = !bypass && (behind || outside);
    end
endmodule

// File: rtl/zc_out_stage.sv
module zc_out_stage
    import zcull_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  frag_t load_frag,
    input  logic  out_ready,
    output logic  out_valid,
    output frag_t out_frag,
    output logic  can_take
);
    typedef struct packed {
        logic  valid;
        frag_t frag;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.valid = 1'b1;
            s_d.frag  = load_frag;
        end else if (out_ready) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.valid;
    assign out_frag  = s_q.frag;
    assign can_take  = !s_q.valid || out_ready;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_frag)));
endmodule

// File: rtl/zc_cull_counter.sv
module zc_cull_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr)      s_d.cnt = '0;
        else if (inc) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1));
endmodule

// File: rtl/zcull_filter.sv
module zcull_filter
    import zcull_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [Z_W-1:0]     in_z,
    input  logic [PAY_W-1:0]   in_payload,
    input  logic               cfg_shader_writes_z,
    input  logic [Z_W-1:0]     cfg_zmin,
    input  logic [Z_W-1:0]     cfg_zmax,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_x,
    input  logic [IDX_W-1:0]   wr_y,
    input  logic [Z_W-1:0]     wr_z,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [COORD_W-1:0] out_x,
    output logic [COORD_W-1:0] out_y,
    output logic [Z_W-1:0]     out_z,
    output logic [PAY_W-1:0]   out_payload,
    input  logic               cull_clr,
    output logic [CNT_W-1:0]   cull_count
);
    logic           fire;
    logic           cull;
    logic [Z_W-1:0] store_z;
    frag_t          in_frag, o_frag;

    assign in_frag = '{x: in_x, y: in_y, z: in_z, pay: in_payload};
    assign fire    = in_valid && in_ready;

    zc_depth_store #(.Z_W(Z_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_x(in_x[IDX_W-1:0]), .rd_y(in_y[IDX_W-1:0]), .rd_z(store_z),
        .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_z(wr_z)
    );

    zc_compare #(.Z_W(Z_W)) u_cmp (
        .frag_z(in_z), .store_z(store_z), .zmin(cfg_zmin), .zmax(cfg_zmax),
        .bypass(cfg_shader_writes_z), .cull(cull)
    );

    zc_out_stage u_out (
        .clk(clk), .rst_n(rst_n),
        .load(fire && !cull), .load_frag(in_frag),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_frag(o_frag), .can_take(in_ready)
    );

    zc_cull_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(fire && cull), .clr(cull_clr),
        .count(cull_count)
    );

    assign out_x       = o_frag.x;
    assign out_y       = o_frag.y;
    assign out_z       = o_frag.z;
    assign out_payload = o_frag.pay;

    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cfg_shader_writes_z) |=> (out_valid && out_payload == $past(in_payload)));
    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cull) |=> (out_valid && out_z == $past(in_z) && out_x == $past(in_x)));
    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cfg_shader_writes_z && (in_z < cfg_zmin || in_z > cfg_zmax) && !cull_clr)
        |=> cull_count == $past(cull_count) + 1'b1);
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/sim_zcull_filter.sv
module sim_zcull_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_x = '0, in_y = '0;
    logic [15:0] in_z = '0;
    logic [31:0] in_payload = '0;
    logic        cfg_shader_writes_z = 1'b0;
    logic [15:0] cfg_zmin = 16'h0000, cfg_zmax = 16'hFFFF;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_x = '0, wr_y = '0;
    logic [15:0] wr_z = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_x, out_y;
    logic [15:0] out_z;
    logic [31:0] out_payload;
    logic        cull_clr = 1'b0;
    logic [31:0] cull_count;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    logic [31:0] exp_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    zcull_filter u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            finish_run();
        end
    end

    task automatic store_write(input logic [3:0] x, input logic [3:0] y, input logic [15:0] z);
        @(negedge clk);
        wr_en = 1; wr_x = x; wr_y = y; wr_z = z;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Send one fragment with out_ready=1 and check whether it is forwarded.
    task automatic send(string req, input logic [7:0] x, input logic [7:0] y,
                        input logic [15:0] z, input logic [31:0] pay, input bit pass);
        @(negedge clk);
        in_valid = 1; in_x = x; in_y = y; in_z = z; in_payload = pay;
        @(negedge clk);
        in_valid = 0;
        #1;
        if (!pass) exp_cnt++;
        check(req, {31'd0, out_valid}, {31'd0, pass});
        if (pass) begin
            check(req, out_payload, pay);
            check(req, {out_x, out_y, out_z}, {x, y, z});
        end
        check(req, cull_count, exp_cnt);
    endtask

    task automatic t_reset();
        #1;
        check("R1", {30'd0, out_valid, in_ready}, 32'd1);
        check("R1", cull_count, 32'd0);
    endtask

    task automatic t_store_reset();
        send("R3", 8'h05, 8'h0A, 16'hFFFF, 32'hA0000001, 1);
        send("R3", 8'hFF, 8'hFF, 16'hFFFF, 32'hA0000002, 1);
    endtask

    task automatic t_depth();
        store_write(4'h2, 4'h3, 16'h4000);
        send("R2", 8'h02, 8'h03, 16'h4001, 32'hB0000001, 0);
        send("R2", 8'h02, 8'h03, 16'h4000, 32'hB0000002, 1);
        send("R2", 8'h02, 8'h03, 16'h3FFF, 32'hB0000003, 1);
    endtask

    task automatic t_alias();
        send("R10", 8'h12, 8'h33, 16'h5000, 32'hC0000001, 0);
        send("R10", 8'h22, 8'hF3, 16'h1000, 32'hC0000002, 1);
        send("R10", 8'h03, 8'h02, 16'h5000, 32'hC0000003, 1);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        wr_en = 1; wr_x = 4'h7; wr_y = 4'h7; wr_z = 16'h1000;
        in_valid = 1; in_x = 8'h07; in_y = 8'h07; in_z = 16'h8000; in_payload = 32'hD0000001;
        @(negedge clk);
        wr_en = 0; in_valid = 0;
        #1;
        check("R4", {31'd0, out_valid}, 32'd1);
        check("R4", out_payload, 32'hD0000001);
        send("R4", 8'h07, 8'h07, 16'h8000, 32'hD0000002, 0);
        send("R4", 8'h07, 8'h07, 16'h1000, 32'hD0000003, 1);
    endtask

    task automatic t_range();
        cfg_zmin = 16'h0100; cfg_zmax = 16'h0800;
        send("R5", 8'h40, 8'h40, 16'h00FF, 32'hE0000001, 0);
        send("R5", 8'h40, 8'h40, 16'h0100, 32'hE0000002, 1);
        send("R5", 8'h40, 8'h40, 16'h0800, 32'hE0000003, 1);
        send("R5", 8'h40, 8'h40, 16'h0801, 32'hE0000004, 0);
    endtask

    task automatic t_bypass();
        cfg_shader_writes_z = 1;
        send("R6", 8'h40, 8'h40, 16'h00FF, 32'hF0000001, 1);
        send("R6", 8'h40, 8'h40, 16'hFFFF, 32'hF0000002, 1);
        send("R6", 8'h02, 8'h03, 16'h4001, 32'hF0000003, 1);
        cfg_shader_writes_z = 0;
        cfg_zmin = 16'h0000; cfg_zmax = 16'hFFFF;
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 0;
        in_valid = 1; in_x = 8'h01; in_y = 8'h01; in_z = 16'h0010; in_payload = 32'h11110001;
        @(negedge clk);
        in_payload = 32'h11110002; in_z = 16'h0020;
        #1;
        check("R8", {30'd0, out_valid, in_ready}, 32'd2);
        check("R8", out_payload, 32'h11110001);
        @(negedge clk);
        #1;
        check("R8", out_payload, 32'h11110001);
        check("R8", {16'd0, out_z}, 32'h0010);
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        #1;
        check("R7", out_payload, 32'h11110002);
        check("R7", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        #1;
        check("R7", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_clear();
        @(negedge clk);
        cull_clr = 1;
        in_valid = 1; in_x = 8'h02; in_y = 8'h03; in_z = 16'hFFFF; in_payload = 32'h22220001;
        @(negedge clk);
        cull_clr = 0; in_valid = 0;
        #1;
        exp_cnt = 0;
        check("R9", cull_count, 32'd0);
        check("R9", {31'd0, out_valid}, 32'd0);
        send("R9", 8'h02, 8'h03, 16'hFFFE, 32'h22220002, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_store_reset();
        t_depth();
        t_alias();
        t_write_timing();
        t_range();
        t_bypass();
        t_backpressure();
        t_clear();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule